// File: doc/BRIEF.md
# Power-Down and Retention Control Register

This block holds a 16-bit write-only power-management word and turns it into the control lines that a mixed-signal receiver chip needs. The eleven upper bits are individual active-high power enables for the analog and processing sub-blocks. The lowest of these enables also takes the signal processing core out of reset. One bit decides whether the bank of programmed configuration registers keeps its contents when the core leaves power save. Two active-high disable bits stop the crystal oscillator and silence the clock output pin. The last two bits turn on the auxiliary ADC and the automatic receive start-up.

The block makes a single-cycle reset pulse for the program register bank. The pulse fires when the core leaves power save, or when an automatic receive start-up event arrives while start-up is enabled. The retention bit suppresses the pulse in both cases. The clock output pin is gated on its output path by an enable that only changes while the clock is low, so the pin never shows a runt pulse. Writes from the programming port go through only while automatic start-up is off. A write attempted while it is on is dropped and reported by an error pulse.

Top module: `pwr_ctl`

## Requirements
- R1: Power-up reset (`rst`) or bus reset (`bus_rst`) clears every bit of the word to 0: all `blk_en` low, `core_rst` high, `xtal_en` high, `aux_adc_en` and `auto_rx_en` low, and `clk_out` toggling with `clk`.
- R2: A write (`wr_en` high at a rising edge) loads `wr_data` into the word at that edge. Bits 15..5 appear on `blk_en[10:0]` active-high, with bit 5 on `blk_en[0]`.
- R3: `core_rst` is high exactly while bit 5 of the word is 0.
- R4: When bit 5 goes from 0 to 1 while bit 4 is 0, `prog_rst` is high for exactly one cycle, in the cycle that follows the first cycle with the new word.
- R5: When bit 4 is 1, a 0-to-1 change of bit 5 produces no `prog_rst` pulse.
- R6: An `auto_start` pulse sampled while bit 0 is 1 and bit 4 is 0 gives a one-cycle `prog_rst` in the next cycle. With bit 4 at 1 or bit 0 at 0 it gives none.
- R7: `xtal_en` is the inverse of bit 3.
- R8: With bit 2 at 0, `clk_out` follows `clk`. With bit 2 at 1, it is held low. A change of bit 2 takes effect at the next falling edge of `clk`, so the current high phase of `clk_out` finishes unaltered.
- R9: `aux_adc_en` equals bit 1 and `auto_rx_en` equals bit 0.
- R10: `prog_wr_pass` follows `prog_wr` while bit 0 is 0. While bit 0 is 1 it stays low, and `prog_err` is high for the cycle after each blocked write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the source for the clock output pin |
| rst | input | 1 | Synchronous active-high power-up reset |
| bus_rst | input | 1 | Synchronous active-high bus reset, clears the word |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| auto_start | input | 1 | One-cycle automatic receive start-up event |
| prog_wr | input | 1 | Write request from the programming port |
| blk_en | output | 11 | Active-high power enables (word bits 15..5) |
| core_rst | output | 1 | Processing core held in reset and power save |
| prog_rst | output | 1 | One-cycle reset pulse for the program register bank |
| xtal_en | output | 1 | Crystal oscillator enable |
| clk_out | output | 1 | Gated clock output pin |
| aux_adc_en | output | 1 | Auxiliary ADC and its interrupts enabled |
| auto_rx_en | output | 1 | Automatic receive start-up enabled |
| prog_wr_pass | output | 1 | Programming port write allowed through |
| prog_err | output | 1 | One-cycle flag after a blocked programming write |

## Verification
The bench times the program-register pulse to the exact cycle. It checks that the pulse is single-cycle, which catches a design that produces a level instead of an edge. It also checks that the retention bit suppresses the pulse for both core wake-up and auto start-up, which a design that ignores retention on one path would get wrong. The clock output is sampled in the high phase right after a disable is written; a design that gates combinationally cuts that phase short and fails. A bus reset applied over an all-ones word shows whether the inverted oscillator and clock-out bits come back enabled. A blocked programming write must show both a low pass line and the error pulse one cycle later.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;
    localparam int WORD_W = 16;
    localparam int PWR_N  = 11;
    localparam int PWR_LO = WORD_W - PWR_N;

    typedef struct packed {
        logic [PWR_N-1:0] pwr;       // bits 15..5, bit 5 wakes the core
        logic             retain;    // bit 4
        logic             xtal_off;  // bit 3
        logic             clk_off;   // bit 2
        logic             aux_on;    // bit 1
        logic             auto_on;   // bit 0
    } ctl_word_t;

    localparam ctl_word_t WORD_RST = '0;

    function automatic ctl_word_t to_word(input logic [WORD_W-1:0] raw);
        return ctl_word_t'(raw);
    endfunction
endpackage

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
    import pwr_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output ctl_word_t         word_q
);
    always_ff @(posedge clk) begin
        if (rst || bus_rst)
            word_q <= WORD_RST;
        else if (wr_en)
            word_q <= to_word(wr_data);
    end
endmodule

// File: rtl/pwr_ctl_rstgen.sv
module pwr_ctl_rstgen (
    input  logic clk,
    input  logic rst,
    input  logic core_on,
    input  logic retain,
    input  logic auto_on,
    input  logic auto_start,
    output logic prog_rst
);
    logic prev_on;
    logic wake_evt;
    logic auto_evt;

    assign wake_evt = core_on && !prev_on;
    assign auto_evt = auto_start && auto_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_on  <= 1'b0;
            prog_rst <= 1'b0;
        end else begin
            prev_on  <= core_on;
            prog_rst <= !retain && (wake_evt || auto_evt);
        end
    end
endmodule

// File: rtl/pwr_ctl_clkgate.sv
module pwr_ctl_clkgate (
    input  logic clk,
    input  logic rst,
    input  logic gate_off,
    output logic clk_out
);
    logic en_lo;

    // enable only moves while clk is low
    always_ff @(negedge clk) begin
        if (rst)
            en_lo <= 1'b1;
        else
            en_lo <= !gate_off;
    end

    assign clk_out = clk & en_lo;
endmodule

// File: rtl/pwr_ctl_guard.sv
module pwr_ctl_guard (
    input  logic clk,
    input  logic rst,
    input  logic auto_on,
    input  logic prog_wr,
    output logic prog_wr_pass,
    output logic prog_err
);
    assign prog_wr_pass = prog_wr && !auto_on;

    always_ff @(posedge clk) begin
        if (rst)
            prog_err <= 1'b0;
        else
            prog_err <= prog_wr && auto_on;
    end
endmodule

// File: rtl/pwr_ctl.sv
module pwr_ctl
    import pwr_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              auto_start,
    input  logic              prog_wr,
    output logic [PWR_N-1:0]  blk_en,
    output logic              core_rst,
    output logic              prog_rst,
    output logic              xtal_en,
    output logic              clk_out,
    output logic              aux_adc_en,
    output logic              auto_rx_en,
    output logic              prog_wr_pass,
    output logic              prog_err
);
    ctl_word_t word_q;

    pwr_ctl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .bus_rst (bus_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .word_q  (word_q)
    );

    pwr_ctl_rstgen u_rstgen (
        .clk        (clk),
        .rst        (rst),
        .core_on    (word_q.pwr[0]),
        .retain     (word_q.retain),
        .auto_on    (word_q.auto_on),
        .auto_start (auto_start),
        .prog_rst   (prog_rst)
    );

    pwr_ctl_clkgate u_clkgate (
        .clk      (clk),
        .rst      (rst),
        .gate_off (word_q.clk_off),
        .clk_out  (clk_out)
    );

    pwr_ctl_guard u_guard (
        .clk          (clk),
        .rst          (rst),
        .auto_on      (word_q.auto_on),
        .prog_wr      (prog_wr),
        .prog_wr_pass (prog_wr_pass),
        .prog_err     (prog_err)
    );

    assign blk_en     = word_q.pwr;
    assign core_rst   = !word_q.pwr[0];
    assign xtal_en    = !word_q.xtal_off;
    assign aux_adc_en = word_q.aux_on;
    assign auto_rx_en = word_q.auto_on;
endmodule

// File: rtl/pwr_ctl_chk.sv
module pwr_ctl_chk
    import pwr_ctl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_rst,
    input logic             auto_start,
    input logic             prog_wr,
    input logic             retain,
    input logic [PWR_N-1:0] blk_en,
    input logic             core_rst,
    input logic             prog_rst,
    input logic             xtal_en,
    input logic             aux_adc_en,
    input logic             auto_rx_en,
    input logic             prog_wr_pass,
    input logic             prog_err
);
    AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (blk_en == '0) && core_rst && xtal_en && !aux_adc_en && !auto_rx_en); // R1
    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ($fell(core_rst) && !retain) |=> prog_rst); // R4
    AST_RETAIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(retain) |-> !prog_rst); // R5
    AST_AUTO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (auto_start && auto_rx_en && !retain) |=> prog_rst); // R6
    AST_WR_BLOCK: assert property (@(posedge clk) disable iff (rst)
        auto_rx_en |-> !prog_wr_pass); // R10
    AST_WR_ERR: assert property (@(posedge clk) disable iff (rst)
        (prog_wr && auto_rx_en) |=> prog_err); // R10
endmodule

bind pwr_ctl pwr_ctl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_rst      (bus_rst),
    .auto_start   (auto_start),
    .prog_wr      (prog_wr),
    .retain       (word_q.retain),
    .blk_en       (blk_en),
    .core_rst     (core_rst),
    .prog_rst     (prog_rst),
    .xtal_en      (xtal_en),
    .aux_adc_en   (aux_adc_en),
    .auto_rx_en   (auto_rx_en),
    .prog_wr_pass (prog_wr_pass),
    .prog_err     (prog_err)
);

// File: tb/pwr_ctl_tb.sv
module pwr_ctl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        auto_start = 1'b0;
    logic        prog_wr = 1'b0;
    logic [10:0] blk_en;
    logic        core_rst, prog_rst, xtal_en, clk_out;
    logic        aux_adc_en, auto_rx_en, prog_wr_pass, prog_err;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    pwr_ctl u_dut (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .wr_en(wr_en), .wr_data(wr_data),
        .auto_start(auto_start), .prog_wr(prog_wr), .blk_en(blk_en),
        .core_rst(core_rst), .prog_rst(prog_rst), .xtal_en(xtal_en),
        .clk_out(clk_out), .aux_adc_en(aux_adc_en), .auto_rx_en(auto_rx_en),
        .prog_wr_pass(prog_wr_pass), .prog_err(prog_err)
    );

    // vector table: word, then expected blk_en, xtal_en, aux, auto, core_rst
    localparam int NV = 6;
    localparam logic [15:0] V_WORD [NV] = '{16'hFFE0, 16'h0008, 16'hAAA2, 16'h5541, 16'h0029, 16'h0000};
    localparam logic [10:0] V_BLK  [NV] = '{11'h7FF, 11'h000, 11'h555, 11'h2AA, 11'h001, 11'h000};
    localparam logic        V_XTAL [NV] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic        V_AUX  [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic        V_AUTO [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic        V_CORE [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // word loaded at the next rising edge; returns 1 ns after it
    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic next_hi();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        next_hi();
        // R1 reset state
        chk("R1 blk_en", 32'(blk_en), 32'h0);
        chk("R1 core_rst", 32'(core_rst), 32'h1);
        chk("R1 xtal_en", 32'(xtal_en), 32'h1);
        chk("R1 clk_out", 32'(clk_out), 32'h1);
        chk("R1 aux/auto", 32'({aux_adc_en, auto_rx_en}), 32'h0);

        // vector walk: R2 R3 R7 R9
        for (int i = 0; i < NV; i++) begin
            wr(V_WORD[i]);
            #1;
            chk("R2 blk_en", 32'(blk_en), 32'(V_BLK[i]));
            chk("R3 core_rst", 32'(core_rst), 32'(V_CORE[i]));
            chk("R7 xtal_en", 32'(xtal_en), 32'(V_XTAL[i]));
            chk("R9 aux_adc_en", 32'(aux_adc_en), 32'(V_AUX[i]));
            chk("R9 auto_rx_en", 32'(auto_rx_en), 32'(V_AUTO[i]));
        end

        // R4 wake pulse without retention
        wr(16'h0020);
        #1;
        chk("R4 pulse early", 32'(prog_rst), 32'h0);
        next_hi();
        chk("R4 pulse", 32'(prog_rst), 32'h1);
        next_hi();
        chk("R4 single cycle", 32'(prog_rst), 32'h0);

        // R5 wake with retention
        wr(16'h0000);
        next_hi();
        wr(16'h0030);
        next_hi();
        chk("R5 no pulse", 32'(prog_rst), 32'h0);
        next_hi();
        chk("R5 no pulse later", 32'(prog_rst), 32'h0);

        // R6 auto start-up paths
        wr(16'h0021);
        next_hi();
        next_hi();
        @(negedge clk);
        auto_start = 1'b1;
        @(posedge clk);
        #1;
        auto_start = 1'b0;
        #1;
        chk("R6 auto pulse", 32'(prog_rst), 32'h1);
        next_hi();
        chk("R6 auto single", 32'(prog_rst), 32'h0);
        wr(16'h0031);
        @(negedge clk);
        auto_start = 1'b1;
        @(posedge clk);
        #1;
        auto_start = 1'b0;
        #1;
        chk("R6 retained", 32'(prog_rst), 32'h0);
        wr(16'h0020);
        @(negedge clk);
        auto_start = 1'b1;
        @(posedge clk);
        #1;
        auto_start = 1'b0;
        #1;
        chk("R6 auto off", 32'(prog_rst), 32'h0);

        // R8 clock output gating at the falling edge
        next_hi();
        chk("R8 clk_out runs", 32'(clk_out), 32'h1);
        wr(16'h0024);
        #1;
        chk("R8 high phase kept", 32'(clk_out), 32'h1);
        next_hi();
        chk("R8 held low", 32'(clk_out), 32'h0);
        next_hi();
        chk("R8 still low", 32'(clk_out), 32'h0);
        wr(16'h0020);
        next_hi();
        chk("R8 restored", 32'(clk_out), 32'h1);

        // R10 programming port guard
        @(negedge clk);
        prog_wr = 1'b1;
        #1;
        chk("R10 pass open", 32'(prog_wr_pass), 32'h1);
        @(posedge clk);
        #1;
        prog_wr = 1'b0;
        #1;
        chk("R10 no err", 32'(prog_err), 32'h0);
        wr(16'h0021);
        @(negedge clk);
        prog_wr = 1'b1;
        #1;
        chk("R10 pass blocked", 32'(prog_wr_pass), 32'h0);
        @(posedge clk);
        #1;
        prog_wr = 1'b0;
        #1;
        chk("R10 err pulse", 32'(prog_err), 32'h1);
        next_hi();
        chk("R10 err single", 32'(prog_err), 32'h0);

        // R1 bus reset over an all-ones word
        wr(16'hFFFF);
        @(negedge clk);
        bus_rst = 1'b1;
        @(posedge clk);
        #1;
        bus_rst = 1'b0;
        #1;
        chk("R1 bus blk_en", 32'(blk_en), 32'h0);
        chk("R1 bus xtal_en", 32'(xtal_en), 32'h1);
        chk("R1 bus core_rst", 32'(core_rst), 32'h1);
        chk("R1 bus aux/auto", 32'({aux_adc_en, auto_rx_en}), 32'h0);
        next_hi();
        chk("R1 bus clk_out", 32'(clk_out), 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule